// File: doc/BRIEF.md
# Transport-Stream Byte-Parallel Transmitter

This block takes MPEG-2 transport packets from an upstream byte source and drives a byte-wide synchronous parallel output. The output has 8 data bits, a packet-sync flag and a data-valid flag, all registered on the rising edge of one byte clock. Upstream bytes arrive over a ready/valid handshake. A start-of-packet marker tags the first byte of each packet.

Three packet formats are selected by a 2-bit input, which is sampled only when a packet starts:

- **188-byte packets.**
- **204-byte packets carrying 16 extra valid bytes.** All 204 bytes come from the source.
- **204-byte padded packets.** The source supplies only 188 bytes. The transmitter appends 16 fill bytes itself and marks them not-valid.

The first byte of every packet must be the 0x47 sync byte. A packet that starts with any other value is still sent, but it is flagged on an error output. The byte clock of the physical interface must stay at or below 13.5 MHz. That limit is met by whatever clocks this block; the logic makes no assumption about the rate.

Top module: `ts_par_tx`

## Requirements
- R1: While rst_ni is low and in the first cycle after release, out_valid_o, out_sync_o, hdr_err_o and out_data_o are all zero, and in_ready_o is high.
- R2: When the block is idle and accepts a byte with in_sop_i high, that byte is driven on out_data_o with out_sync_o and out_valid_o high. out_sync_o is high for that first byte only, never for a later byte of the same packet.
- R3: When the block is idle, a byte offered without in_sop_i is consumed (in_ready_o high) and discarded. The outputs stay idle (out_valid_o low, out_data_o 0x00).
- R4: fmt_i code 0 (and the spare code 3) selects 188-byte packets. Exactly 188 bytes are taken and 188 valid bytes are driven, with no fill.
- R5: fmt_i code 1 selects padded 204-byte packets. After the 188th source byte, 16 fill cycles follow with out_data_o = 0x00, out_valid_o low and out_sync_o low. During those cycles in_ready_o is low and an offered byte is not consumed.
- R6: fmt_i code 2 selects 204-byte packets in which all 204 bytes are taken from the source and all are driven with out_valid_o high.
- R7: fmt_i is sampled only in the cycle a packet starts. Changes while a packet is in flight do not alter that packet's length or fill.
- R8: hdr_err_o is high exactly in the cycle out_sync_o is high with out_data_o not equal to 0x47.
- R9: If the source has no byte ready inside the payload of a packet, that cycle drives out_valid_o low, out_sync_o low and out_data_o 0x00. The packet position does not advance, so the packet is stretched rather than shortened. Between packets, idle cycles keep out_valid_o and out_sync_o low.
- R10: An accepted byte appears on the outputs exactly one clock later. A new packet can start in the cycle right after the last byte or fill cycle of the previous one, with no idle cycle in between.
- R11: in_ready_o is low only during the fill cycles of the padded format, and high at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Byte clock; rising edge transfers data |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Packet format: 0/3 = 188, 1 = 204 padded, 2 = 204 full |
| in_data_i | input | 8 | Upstream byte |
| in_sop_i | input | 1 | Upstream byte is the first of a packet |
| in_valid_i | input | 1 | Upstream byte present |
| in_ready_o | output | 1 | Block takes the byte this cycle |
| out_data_o | output | 8 | Parallel output byte |
| out_sync_o | output | 1 | Output byte is the first of a packet |
| out_valid_o | output | 1 | Output byte carries data (low for fill and idle) |
| hdr_err_o | output | 1 | First byte of the current packet is not 0x47 |

## Verification
Every output result is due one clock after the stimulus that causes it:

- **Output byte and flags:** a byte accepted at an edge, or a fill or gap decision taken there, shows on out_data_o, out_valid_o, out_sync_o and hdr_err_o after that same edge.
- **Ready:** in_ready_o is combinational from the packet state and is valid in the same cycle as the offered byte.

The bench drives inputs on the falling edge and checks in_ready_o shortly after. It predicts the registered outputs for the coming edge and compares them on the next falling edge. At the end of each packet it also counts the valid bytes seen between sync pulses and compares the count with the format length.

// File: rtl/ts_par_pkg.sv
package ts_par_pkg;
  typedef enum logic [1:0] {
    FMT_188      = 2'd0,
    FMT_204_PAD  = 2'd1,
    FMT_204_FULL = 2'd2,
    FMT_SPARE    = 2'd3
  } ts_fmt_e;
endpackage

// File: rtl/ts_len_sel.sv
module ts_len_sel
  import ts_par_pkg::*;
#(
  parameter int PAY_LEN = 188,
  parameter int EXT_LEN = 16,
  parameter int POS_W   = 8
) (
  input  ts_fmt_e            fmt_i,
  output logic [POS_W-1:0]   take_o,
  output logic [POS_W-1:0]   frame_o
);
  localparam logic [POS_W-1:0] SHORT_LEN = POS_W'(PAY_LEN);
  localparam logic [POS_W-1:0] LONG_LEN  = POS_W'(PAY_LEN + EXT_LEN);

  always_comb begin
    unique case (fmt_i)
      FMT_204_PAD:  begin take_o = SHORT_LEN; frame_o = LONG_LEN;  end
      FMT_204_FULL: begin take_o = LONG_LEN;  frame_o = LONG_LEN;  end
      default:      begin take_o = SHORT_LEN; frame_o = SHORT_LEN; end
    endcase
  end
endmodule

// File: rtl/ts_pos_seq.sv
module ts_pos_seq #(
  parameter int POS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  input  logic [POS_W-1:0] frame_i,
  output logic             busy_o,
  output logic [POS_W-1:0] pos_o
);
  // pos_o = bytes of the current packet already emitted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      pos_o  <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        pos_o  <= POS_W'(1);
      end
    end else if (step_i) begin
      if (pos_o == frame_i - POS_W'(1)) begin
        busy_o <= 1'b0;
        pos_o  <= '0;
      end else begin
        pos_o <= pos_o + POS_W'(1);
      end
    end
  end
endmodule

// File: rtl/ts_out_stage.sv
module ts_out_stage #(
  parameter int          DW        = 8,
  parameter logic [DW-1:0] SYNC_BYTE = 8'h47
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          sync_o,
  output logic          err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      sync_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      data_o  <= load_i ? data_i : '0;
      valid_o <= load_i;
      sync_o  <= start_i;
      err_o   <= start_i && (data_i != SYNC_BYTE);
    end
  end
endmodule

// File: rtl/ts_par_tx.sv
module ts_par_tx
  import ts_par_pkg::*;
#(
  parameter int            DW        = 8,
  parameter int            PAY_LEN   = 188,
  parameter int            EXT_LEN   = 16,
  parameter logic [DW-1:0] SYNC_BYTE = 8'h47
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    fmt_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_sop_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  output logic [DW-1:0] out_data_o,
  output logic          out_sync_o,
  output logic          out_valid_o,
  output logic          hdr_err_o
);
  localparam int POS_W = $clog2(PAY_LEN + EXT_LEN + 1);

  ts_fmt_e          fmt_q;
  logic             busy, in_pad, start, pay, step;
  logic [POS_W-1:0] pos, take_len, frame_len;

  assign in_pad     = busy && (pos >= take_len);
  assign in_ready_o = !in_pad;
  assign start      = !busy && in_valid_i && in_sop_i;
  assign pay        = busy && !in_pad && in_valid_i;
  assign step       = pay || in_pad;

  // format latched once per packet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    fmt_q <= FMT_188;
    else if (start) fmt_q <= ts_fmt_e'(fmt_i);
  end

  ts_len_sel #(.PAY_LEN(PAY_LEN), .EXT_LEN(EXT_LEN), .POS_W(POS_W)) u_len (
    .fmt_i   (fmt_q),
    .take_o  (take_len),
    .frame_o (frame_len)
  );

  ts_pos_seq #(.POS_W(POS_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .step_i  (step),
    .frame_i (frame_len),
    .busy_o  (busy),
    .pos_o   (pos)
  );

  ts_out_stage #(.DW(DW), .SYNC_BYTE(SYNC_BYTE)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start || pay),
    .start_i (start),
    .data_i  (in_data_i),
    .data_o  (out_data_o),
    .valid_o (out_valid_o),
    .sync_o  (out_sync_o),
    .err_o   (hdr_err_o)
  );
endmodule

// File: rtl/ts_par_tx_chk.sv
module ts_par_tx_chk #(
  parameter int            DW        = 8,
  parameter logic [DW-1:0] SYNC_BYTE = 8'h47
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_sop_i,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic [DW-1:0] out_data_o,
  input logic          out_sync_o,
  input logic          out_valid_o,
  input logic          hdr_err_o,
  input logic          busy,
  input logic          in_pad,
  input logic [1:0]    fmt_q
);
  assert_sync_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sync_o |-> out_valid_o);
  assert_sync_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sync_o |=> !out_sync_o);
  assert_hdr_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sync_o |-> (hdr_err_o == (out_data_o != SYNC_BYTE)));
  assert_err_needs_sync_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_err_o |-> out_sync_o);
  assert_pad_out_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pad |=> (!out_valid_o && !out_sync_o && out_data_o == '0));
  assert_pad_no_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> in_pad);
  assert_no_fill_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && (fmt_q == 2'd2 || fmt_q == 2'd0 || fmt_q == 2'd3)) |-> !in_pad);
  assert_start_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && in_valid_i && in_sop_i) |=> (out_sync_o && out_valid_o));
  assert_idle_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !(in_valid_i && in_sop_i)) |=> (!out_valid_o && !out_sync_o));
  assert_gap_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !in_pad && !in_valid_i) |=> (!out_valid_o && out_data_o == '0));
endmodule

bind ts_par_tx ts_par_tx_chk #(.DW(DW), .SYNC_BYTE(SYNC_BYTE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_sop_i    (in_sop_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_data_o  (out_data_o),
  .out_sync_o  (out_sync_o),
  .out_valid_o (out_valid_o),
  .hdr_err_o   (hdr_err_o),
  .busy        (busy),
  .in_pad      (in_pad),
  .fmt_q       (fmt_q)
);

// File: tb/ts_par_tx_bench.sv
`timescale 1ns/1ps
module ts_par_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic [7:0] din = 8'h00;
  logic       sop = 1'b0, vld = 1'b0;
  logic       rdy, osync, ovalid, oerr;
  logic [7:0] odata;

  always #2.5 clk = ~clk;

  ts_par_tx u_ts_par_tx (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .in_data_i(din), .in_sop_i(sop),
    .in_valid_i(vld), .in_ready_o(rdy), .out_data_o(odata), .out_sync_o(osync),
    .out_valid_o(ovalid), .hdr_err_o(oerr)
  );

  int n_chk = 0, n_err = 0;
  // bench-side packet model built from the requirements
  bit m_in = 0;
  int m_pos = 0, m_take = 188, m_frame = 188;
  int act_cnt = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int take_of(input int f);
    return (f == 2) ? 204 : 188;
  endfunction
  function automatic int frame_of(input int f);
    return (f == 1 || f == 2) ? 204 : 188;
  endfunction

  // one cycle: drive at negedge, check ready, predict, check after next edge
  task automatic step(input bit v, input bit s, input logic [7:0] d, input logic [1:0] f);
    bit r, st, py, pd;
    string tag;
    int e_dat, e_val, e_syn, e_err;
    vld = v; sop = s; din = d; fmt = f;
    #1;
    pd = m_in && (m_pos >= m_take);
    r  = !pd;
    chk(pd ? "R5 ready" : "R11 ready", int'(rdy), int'(r));
    st = !m_in && v && s;
    py = m_in && !pd && v;
    e_val = int'(st || py);
    e_dat = (st || py) ? int'(d) : 0;
    e_syn = int'(st);
    e_err = int'(st && d != 8'h47);
    if (st)                       tag = "R2";
    else if (pd)                  tag = "R5";
    else if (m_in && !v)          tag = "R9";
    else if (!m_in)               tag = "R3";
    else if (m_take == 204)       tag = "R6";
    else                          tag = "R4";
    if (st) begin
      m_take = take_of(int'(f)); m_frame = frame_of(int'(f));
      m_in = 1; m_pos = 1;
    end else if (py || pd) begin
      if (m_pos == m_frame - 1) begin m_in = 0; m_pos = 0; end
      else m_pos++;
    end
    @(negedge clk);
    chk({tag, " data"},  int'(odata),  e_dat);
    chk({tag, " valid"}, int'(ovalid), e_val);
    chk({tag, " sync R10"}, int'(osync), e_syn);
    chk("R8 hdr_err", int'(oerr), e_err);
    if (osync) act_cnt = 1;
    else if (ovalid) act_cnt++;
  endtask

  task automatic send_pkt(input logic [1:0] f, input logic [7:0] hdr,
                          input bit gaps, input bit fmt_mid, input bit poke_pad);
    logic [1:0] fc = f;
    int n = take_of(int'(f));
    for (int i = 0; i < n; i++) begin
      if (i > 0 && gaps && ($urandom % 8 == 0)) step(1'b0, 1'b0, 8'($urandom), fc);
      step(1'b1, i == 0, (i == 0) ? hdr : 8'($urandom), fc);
      if (i == 0 && fmt_mid) fc = 2'($urandom);
    end
    if (poke_pad && m_in) step(1'b1, 1'b1, 8'h47, fc); // offered in fill: not taken (R5)
    while (m_in) step(1'b0, 1'b0, 8'h00, fc);
    chk((f == 2) ? "R6 count R7" : ((f == 1) ? "R5 count R7" : "R4 count R7"),
        act_cnt, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20071017));
    #1;
    chk("R1 valid", int'(ovalid), 0);
    chk("R1 sync", int'(osync), 0);
    chk("R1 err", int'(oerr), 0);
    chk("R1 data", int'(odata), 0);
    chk("R1 ready", int'(rdy), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 8'h00, 2'd0);           // R1 first cycle after release
    repeat (3) step(1'b1, 1'b0, 8'h47, 2'd0); // R3 non-sop bytes dropped
    send_pkt(2'd0, 8'h47, 0, 0, 0);           // R4
    send_pkt(2'd0, 8'h47, 0, 0, 0);           // R10 back-to-back
    send_pkt(2'd1, 8'h47, 0, 0, 1);           // R5 fill, poke during fill
    send_pkt(2'd2, 8'h47, 0, 1, 0);           // R6 + R7 fmt change mid-packet
    send_pkt(2'd1, 8'h47, 0, 1, 0);           // R7 padded with fmt change
    send_pkt(2'd0, 8'h12, 0, 0, 0);           // R8 bad header
    send_pkt(2'd3, 8'h47, 0, 0, 0);           // R4 spare code
    send_pkt(2'd2, 8'h47, 1, 0, 0);           // R9 gaps inside packet
    for (int k = 0; k < 24; k++) begin
      repeat ($urandom % 3) step(1'b0, 1'b0, 8'($urandom), 2'($urandom));
      send_pkt(2'($urandom), ($urandom % 4 == 0) ? 8'($urandom) : 8'h47,
               $urandom % 2 == 1, $urandom % 2 == 1, $urandom % 2 == 1);
    end
    repeat (2) step(1'b0, 1'b0, 8'h00, 2'd0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule